// File: doc/BRIEF.md
# Fixed-Priority Exception Priority Resolver

This block picks the most urgent pending exception from a set of requests. It returns the exception number, the effective signed priority and a valid flag. Exceptions 1 to 3 (Reset, NMI, HardFault) have fixed negative priorities. Every higher-numbered exception has an 8-bit programmable priority held in a local register.

A static configuration input chooses between two profiles. In the legacy profile, Reset has priority -3. In the security-extended profile, Reset has priority -4 and a separate Secure HardFault request line is honoured. A run-time control bit places that Secure HardFault either above NMI or below it. Writing the control bit updates the stored Secure HardFault priority on the write edge, and the next selection uses the new value.

Selection is combinational over the whole pending set. The result is registered on the next clock edge. When nothing is pending, the registered number and priority keep their last values.

Top module: `exc_prio_resolver`

## Requirements
- R1: In the legacy profile (`sec_profile`=0) the effective priorities are Reset (number 1) = -3, NMI (number 2) = -2 and HardFault (number 3) = -1.
- R2: In the security-extended profile (`sec_profile`=1) Reset is -4, NMI is -2 and Non-Secure HardFault (`pend[3]`) is -1.
- R3: In the security-extended profile with the control bit at 1, Secure HardFault (`pend_shf`) has priority -3. It beats NMI and loses to Reset.
- R4: With the control bit at 0, Secure HardFault has priority -1 and loses to NMI. The control bit resets to 0.
- R5: A control write (`ctl_we`=1, value `ctl_wdata`) changes the Secure HardFault priority on its own edge. The result registered on that edge still uses the old priority, and the result registered on the next edge uses the new one.
- R6: The stored Secure HardFault priority is only ever -1 or -3. `shf_bad` goes to 1 when it holds any other value.
- R7: Exceptions 4 to NUM_EXC-1 take an 8-bit unsigned priority, zero-extended to a 9-bit signed value, so they are always non-negative and lose to every fixed exception. Priorities are written with `prio_we`/`prio_num`/`prio_wdata` and reset to 0.
- R8: At equal priority the lower exception number wins. A Secure HardFault at -1 beats a Non-Secure HardFault at -1. A Secure HardFault is reported as number 3 with `win_sec`=1.
- R9: The winner of the inputs and registers present before a rising edge appears on the outputs after that edge. `win_prio` is 9-bit two's complement.
- R10: When nothing is pending, `win_valid` is 0 and `win_num`, `win_sec` and `win_prio` hold their previous values. After reset all outputs are 0.
- R11: In the legacy profile, `pend_shf` and control writes are ignored, and `win_sec` is never 1.
- R12: Priority writes to exception numbers below 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_profile | input | 1 | 0 = legacy profile, 1 = security-extended profile (static) |
| pend | input | NUM_EXC-1 | Pending requests, bit i = exception number i (1..NUM_EXC-1) |
| pend_shf | input | 1 | Secure HardFault pending |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_wdata | input | 1 | Control bit value: 1 places Secure HardFault above NMI |
| prio_we | input | 1 | Programmable priority write strobe |
| prio_num | input | $clog2(NUM_EXC) | Exception number to write |
| prio_wdata | input | PRIO_W | Programmable priority value |
| win_valid | output | 1 | A winner was selected |
| win_num | output | $clog2(NUM_EXC) | Winning exception number |
| win_sec | output | 1 | Winner is the Secure HardFault |
| win_prio | output | PRIO_W+1 | Effective signed priority of the winner |
| shf_bad | output | 1 | Secure HardFault priority register holds an illegal value |

## Verification
A wrong Secure HardFault priority shows up one edge after the first cycle in which that request competes with NMI or with a Non-Secure HardFault: the wrong exception or a wrong `win_prio` reaches the outputs. A corrupted value outside {-1, -3} also raises `shf_bad` in the same cycle. A stale control bit shows one edge later than expected, so the bench checks the write edge and the edge after it separately. Programmable registers that are wrong or sign-extended show as soon as such an exception competes with another pending exception.

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver #(
  parameter int NUM_EXC = 16,
  parameter int PRIO_W  = 8,
  localparam int NUM_W  = $clog2(NUM_EXC),
  localparam int SP_W   = PRIO_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_profile,
  input  logic [NUM_EXC-1:1]     pend,
  input  logic                   pend_shf,
  input  logic                   ctl_we,
  input  logic                   ctl_wdata,
  input  logic                   prio_we,
  input  logic [NUM_W-1:0]       prio_num,
  input  logic [PRIO_W-1:0]      prio_wdata,
  output logic                   win_valid,
  output logic [NUM_W-1:0]       win_num,
  output logic                   win_sec,
  output logic signed [SP_W-1:0] win_prio,
  output logic                   shf_bad
);

  localparam logic signed [SP_W-1:0] P_RST_SEC = -4;
  localparam logic signed [SP_W-1:0] P_RST_LEG = -3;
  localparam logic signed [SP_W-1:0] P_SHF_HI  = -3;
  localparam logic signed [SP_W-1:0] P_NMI     = -2;
  localparam logic signed [SP_W-1:0] P_HF      = -1;

  logic signed [SP_W-1:0] rst_prio_q;
  logic signed [SP_W-1:0] shf_prio_q;
  logic [PRIO_W-1:0]      prio_q [4:NUM_EXC-1];
  logic signed [SP_W-1:0] eff    [1:NUM_EXC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_prio_q <= sec_profile ? P_RST_SEC : P_RST_LEG;
      shf_prio_q <= P_HF;
    end else if (ctl_we && sec_profile) begin
      shf_prio_q <= ctl_wdata ? P_SHF_HI : P_HF;
    end
  end

  assign shf_bad = (shf_prio_q != P_HF) && (shf_prio_q != P_SHF_HI);

  for (genvar g = 1; g < NUM_EXC; g++) begin : g_eff
    if (g == 1) begin : g_rst
      assign eff[g] = rst_prio_q;
    end else if (g == 2) begin : g_nmi
      assign eff[g] = P_NMI;
    end else if (g == 3) begin : g_hf
      assign eff[g] = P_HF;
    end else begin : g_prog
      always_ff @(posedge clk) begin
        if (!rst_n)
          prio_q[g] <= '0;
        else if (prio_we && prio_num == NUM_W'(g))
          prio_q[g] <= prio_wdata;
      end
      assign eff[g] = {1'b0, prio_q[g]};
    end
  end

  logic                   sel_valid;
  logic [NUM_W-1:0]       sel_num;
  logic                   sel_sec;
  logic signed [SP_W-1:0] sel_prio;

  always_comb begin
    sel_valid = 1'b0;
    sel_num   = '0;
    sel_sec   = 1'b0;
    sel_prio  = '0;
    if (sec_profile && pend_shf) begin
      sel_valid = 1'b1;
      sel_num   = NUM_W'(3);
      sel_sec   = 1'b1;
      sel_prio  = shf_prio_q;
    end
    for (int i = 1; i < NUM_EXC; i++) begin
      if (pend[i] && (!sel_valid || eff[i] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_num   = NUM_W'(i);
        sel_sec   = 1'b0;
        sel_prio  = eff[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_num   <= '0;
      win_sec   <= 1'b0;
      win_prio  <= '0;
    end else begin
      win_valid <= sel_valid;
      if (sel_valid) begin
        win_num  <= sel_num;
        win_sec  <= sel_sec;
        win_prio <= sel_prio;
      end
    end
  end

endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk #(
  parameter int NUM_EXC = 16,
  parameter int PRIO_W  = 8,
  localparam int NUM_W  = $clog2(NUM_EXC),
  localparam int SP_W   = PRIO_W + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sec_profile,
  input logic [NUM_EXC-1:1]     pend,
  input logic                   pend_shf,
  input logic                   win_valid,
  input logic [NUM_W-1:0]       win_num,
  input logic                   win_sec,
  input logic signed [SP_W-1:0] win_prio,
  input logic                   shf_bad
);
  localparam logic signed [SP_W-1:0] M4 = -4;
  localparam logic signed [SP_W-1:0] M3 = -3;
  localparam logic signed [SP_W-1:0] M2 = -2;
  localparam logic signed [SP_W-1:0] M1 = -1;

  logic any_pend;
  assign any_pend = (|pend) || (sec_profile && pend_shf);

  assert_shf_legal_R6: assert property (@(posedge clk) disable iff (!rst_n) !shf_bad);

  assert_reset_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num == NUM_W'(1)) |-> (win_prio == (sec_profile ? M4 : M3)));

  assert_nmi_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num == NUM_W'(2)) |-> (win_prio == M2));

  assert_sec_winner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_sec) |-> (sec_profile && win_num == NUM_W'(3) && (win_prio == M1 || win_prio == M3)));

  assert_prog_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num >= NUM_W'(4)) |-> !win_prio[SP_W-1]);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> win_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> (!win_valid && $stable(win_num) && $stable(win_prio) && $stable(win_sec)));
endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_profile(sec_profile), .pend(pend), .pend_shf(pend_shf),
  .win_valid(win_valid), .win_num(win_num), .win_sec(win_sec), .win_prio(win_prio),
  .shf_bad(shf_bad)
);

// File: tb/tb_exc_prio_resolver.sv
module tb_exc_prio_resolver;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_profile = 1'b0;
  logic [N-1:1] pend = '0;
  logic pend_shf = 1'b0;
  logic ctl_we = 1'b0, ctl_wdata = 1'b0;
  logic prio_we = 1'b0;
  logic [3:0] prio_num = '0;
  logic [7:0] prio_wdata = '0;
  logic win_valid, win_sec, shf_bad;
  logic [3:0] win_num;
  logic signed [8:0] win_prio;

  exc_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .sec_profile(sec_profile), .pend(pend), .pend_shf(pend_shf),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .prio_we(prio_we), .prio_num(prio_num),
    .prio_wdata(prio_wdata), .win_valid(win_valid), .win_num(win_num), .win_sec(win_sec),
    .win_prio(win_prio), .shf_bad(shf_bad)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  logic signed [8:0] expp_q[$];
  string tag_q[$];

  bit tb_sec, tb_ctl;
  int tb_prio [4:N-1];
  logic [3:0] last_n;
  logic last_s;
  logic signed [8:0] last_p;

  function automatic int fixed_or_prog(int i);
    if (i == 1) return tb_sec ? -4 : -3;
    if (i == 2) return -2;
    if (i == 3) return -1;
    return tb_prio[i];
  endfunction

  task automatic expect_for(input logic [N-1:1] p, input logic shf, input string tag);
    int best = 1000;
    bit found = 0;
    int shf_p = tb_ctl ? -3 : -1;
    logic [3:0] n = last_n;
    logic s = last_s;
    logic signed [8:0] pv = last_p;
    bit use_shf = tb_sec && shf;
    if (use_shf) begin best = shf_p; found = 1; end
    for (int i = 1; i < N; i++)
      if (p[i] && fixed_or_prog(i) < best) begin best = fixed_or_prog(i); found = 1; end
    if (found) begin
      if (use_shf && shf_p == best) begin n = 4'd3; s = 1'b1; end
      else begin
        s = 1'b0;
        for (int i = N - 1; i >= 1; i--)
          if (p[i] && fixed_or_prog(i) == best) n = 4'(i);
      end
      pv = 9'(best);
      last_n = n; last_s = s; last_p = pv;
    end
    exp_q.push_back({found, n, s, 6'd0});
    expp_q.push_back(pv);
    tag_q.push_back(tag);
  endtask

  task automatic step(input logic [N-1:1] p, input logic shf, input logic cwe,
                      input logic cval, input string tag);
    @(negedge clk);
    pend = p; pend_shf = shf; ctl_we = cwe; ctl_wdata = cval;
    @(posedge clk);
    expect_for(p, shf, tag);
    if (cwe && tb_sec) tb_ctl = cval;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic write_prio(input int num, input int val);
    @(negedge clk);
    prio_we = 1'b1; prio_num = 4'(num); prio_wdata = 8'(val);
    @(negedge clk);
    prio_we = 1'b0;
    if (num >= 4) tb_prio[num] = val;
  endtask

  task automatic do_reset(input bit sec);
    @(negedge clk);
    rst_n = 1'b0; sec_profile = sec; pend = '0; pend_shf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tb_sec = sec; tb_ctl = 0;
    for (int i = 4; i < N; i++) tb_prio[i] = 0;
    last_n = '0; last_s = 1'b0; last_p = '0;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      logic signed [8:0] ep;
      string t;
      e = exp_q.pop_front(); ep = expp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (win_valid !== e[11] || win_num !== e[10:7] || win_sec !== e[6] ||
          win_prio !== ep || shf_bad !== 1'b0) begin
        fails++;
        $display("FAIL %s: got v=%0d n=%0d s=%0d p=%0d bad=%0d expected v=%0d n=%0d s=%0d p=%0d bad=0",
                 t, win_valid, win_num, win_sec, win_prio, shf_bad, e[11], e[10:7], e[6], ep);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam logic [N-1:1] B1 = 15'h0001, B2 = 15'h0002, B3 = 15'h0004;
  function automatic logic [N-1:1] bit_of(int i);
    return (N-1)'(1) << (i - 1);
  endfunction

  initial begin
    // Legacy profile
    do_reset(0);
    step('0, 0, 0, 0, "R10 reset outputs");
    step(B1 | B2 | B3 | bit_of(5), 0, 0, 0, "R1 legacy reset wins");
    step(B2 | B3, 0, 0, 0, "R1 legacy nmi");
    step(B3 | bit_of(4), 0, 0, 0, "R1 R7 legacy hardfault over prog");
    step('0, 1, 1, 1, "R11 legacy shf and ctl ignored");
    step(B3, 1, 0, 0, "R11 legacy shf never wins");
    write_prio(5, 10); write_prio(6, 3); write_prio(7, 3);
    step(bit_of(5) | bit_of(6) | bit_of(7), 0, 0, 0, "R8 R7 tie lower number");
    write_prio(2, 0);
    step(B2 | bit_of(6), 0, 0, 0, "R12 write to fixed ignored");
    write_prio(9, 200);
    step(bit_of(9) | bit_of(5), 0, 0, 0, "R7 prog compare");
    step(bit_of(9), 0, 0, 0, "R7 zero extension");
    step('0, 0, 0, 0, "R10 idle hold");
    // Security-extended profile
    do_reset(1);
    step(bit_of(5), 0, 0, 0, "R7 prog reset to zero");
    step(B1 | B2, 1, 0, 0, "R2 secure reset -4");
    step(B2 | B3, 1, 0, 0, "R4 shf below nmi");
    step(B3, 1, 0, 0, "R8 shf beats ns hardfault");
    step(B3, 0, 0, 0, "R2 ns hardfault");
    step(B2, 1, 1, 1, "R5 write edge uses old");
    step(B2, 1, 0, 0, "R3 R5 shf above nmi after write");
    step(B1, 1, 0, 0, "R3 reset beats shf");
    step(B3, 1, 0, 0, "R3 shf over ns hardfault");
    step(B2, 1, 1, 0, "R5 write back edge uses old");
    step(B2, 1, 0, 0, "R4 R5 nmi after clear");
    step('0, 0, 0, 0, "R10 idle hold secure");
    step(B3, 0, 0, 0, "R6 hardfault after idle");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule